// File: doc/BRIEF.md
# Write-Back Set-Associative Cache Tag Controller

This block keeps the tags and line state for a write-back, write-allocate, set-associative cache. Requests of 32 bits arrive through a valid/ready handshake. The block splits each address into a tag, a set index and a block offset, then compares the tag against every way of the indexed set. Each way stores a valid bit, a dirty bit and a recency rank. The data array lives outside this block.

A hit updates the recency ranks, and a write hit also marks the line dirty. A miss allocates a way at once. The block then sends the next level a write-back of the displaced line, if that line is dirty, and after it a read of the missing block. New requests are refused until the next level has taken every outstanding transfer. Single-cycle event pulses feed external statistics counters.

Top module: `wb_tag_ctrl`

## Requirements
- R1: The low log2(BLOCK_BYTES) address bits are the offset, the next log2(SETS) bits are the set index (always 0 when SETS is 1), and the remaining upper bits are the tag. Sets are independent of one another.
- R2: After reset every way is invalid and clean, way j of every set holds rank j (rank 0 means most recently used), req_ready is 1, mem_valid is 0 and all pulses are 0.
- R3: A request whose tag matches a valid way of its set is a hit. The cycle after acceptance, hit_o pulses, no next-level transfer starts and req_ready stays 1.
- R4: When a way with old rank r is hit or filled, every way of that set with rank below r goes up by one and the touched way becomes rank 0. When r is 0, no rank changes.
- R5: On a miss the victim is the lowest-numbered invalid way. If every way is valid, the victim is the way whose rank is WAYS-1.
- R6: A write hit sets the dirty bit of the hit way. A write miss installs the line dirty. A read miss installs it clean.
- R7: When the victim is valid and dirty, the next-level transfer after acceptance is a write (mem_write=1). Its address is (victim tag << (index+offset bits)) | (set index << offset bits). wb_o pulses in the cycle after acceptance.
- R8: Every miss issues a next-level read (mem_write=0) at the request address with the offset bits cleared. It follows the write-back when there is one, and comes first otherwise.
- R9: While a transfer is pending (mem_valid=1), req_ready is 0 and no request is accepted. While mem_ready is 0, mem_addr and mem_write hold steady.
- R10: rd_miss_o or wr_miss_o pulses for one cycle after a read miss or a write miss is accepted. At most one of hit_o, rd_miss_o and wr_miss_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request byte address |
| mem_valid | output | 1 | Next-level transfer pending |
| mem_ready | input | 1 | Next level takes the transfer this cycle |
| mem_write | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | ADDR_W | Block address of the transfer |
| hit_o | output | 1 | Hit event pulse |
| rd_miss_o | output | 1 | Read miss event pulse |
| wr_miss_o | output | 1 | Write miss event pulse |
| wb_o | output | 1 | Write-back event pulse |

## Verification
The assertions check the handshake on every cycle. They confirm that no request is accepted while a transfer is pending, that a stalled transfer holds its address, that a write-back is always followed by a fill, that fill addresses have a zero offset, that a hit causes no traffic, and that the event pulses never overlap. Some behaviour spans many requests: the rank order, victim choice, dirty tracking and the rebuilt write-back address. Only the bench's request sequences can show these. They fill a set, move its ranks with hits, and then evict lines whose clean or dirty state and write-back address are already known.

// File: rtl/wb_tag_ctrl.sv
module wb_tag_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int SETS        = 4,
  parameter int WAYS        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              hit_o,
  output logic              rd_miss_o,
  output logic              wr_miss_o,
  output logic              wb_o
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int SET_W  = (SETS > 1) ? IDX_W : 1;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} state_t;
  state_t state;

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [WAY_W-1:0] rank_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAYS-1:0]  drt_q  [SETS];
  logic [ADDR_W-1:0] wb_addr_q, fill_addr_q;

  logic [SET_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = (SETS == 1) ? '0 : SET_W'(req_addr >> OFF_W);
  assign tag = TAG_W'(req_addr >> (OFF_W + IDX_W));

  logic             hit, any_inv, vic_dirty, accept;
  logic [WAY_W-1:0] hit_way, inv_way, lru_way, victim, touch, old_r;

  always_comb begin
    hit = 1'b0; hit_way = '0;
    any_inv = 1'b0; inv_way = '0;
    lru_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[idx][w] && tag_q[idx][w] == tag) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (!vld_q[idx][w]) begin
        any_inv = 1'b1; inv_way = WAY_W'(w);
      end
      if (rank_q[idx][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
    end
  end

  assign victim    = any_inv ? inv_way : lru_way;
  assign touch     = hit ? hit_way : victim;
  assign old_r     = rank_q[idx][touch];
  assign vic_dirty = vld_q[idx][victim] && drt_q[idx][victim];
  assign accept    = req_valid && (state == S_IDLE);

  wire [ADDR_W-1:0] wb_addr_n   = (ADDR_W'(tag_q[idx][victim]) << (OFF_W + IDX_W))
                                | (ADDR_W'(idx) << OFF_W);
  wire [ADDR_W-1:0] fill_addr_n = req_addr & ~(ADDR_W'(BLOCK_BYTES) - ADDR_W'(1));

  assign req_ready = (state == S_IDLE);
  assign mem_valid = (state != S_IDLE);
  assign mem_write = (state == S_WB);
  assign mem_addr  = (state == S_WB) ? wb_addr_q : fill_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      wb_addr_q   <= '0;
      fill_addr_q <= '0;
      hit_o       <= 1'b0;
      rd_miss_o   <= 1'b0;
      wr_miss_o   <= 1'b0;
      wb_o        <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        drt_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          rank_q[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      hit_o     <= accept && hit;
      rd_miss_o <= accept && !hit && !req_write;
      wr_miss_o <= accept && !hit && req_write;
      wb_o      <= accept && !hit && vic_dirty;
      case (state)
        S_IDLE: if (accept) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch)          rank_q[idx][w] <= '0;
            else if (rank_q[idx][w] < old_r) rank_q[idx][w] <= rank_q[idx][w] + 1'b1;
          end
          if (hit) begin
            if (req_write) drt_q[idx][hit_way] <= 1'b1;
          end else begin
            tag_q[idx][victim] <= tag;
            vld_q[idx][victim] <= 1'b1;
            drt_q[idx][victim] <= req_write;
            wb_addr_q          <= wb_addr_n;
            fill_addr_q        <= fill_addr_n;
            state              <= vic_dirty ? S_WB : S_FILL;
          end
        end
        S_WB:    if (mem_ready) state <= S_FILL;
        S_FILL:  if (mem_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module wb_tag_ctrl_chk #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              hit_o,
  input logic              rd_miss_o,
  input logic              wr_miss_o,
  input logic              wb_o
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));
  a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && mem_ready |=> mem_valid && !mem_write);
  a_r7_wb_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    wb_o |-> (rd_miss_o || wr_miss_o) && mem_valid && mem_write);
  a_r8_miss_transfers: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_miss_o || wr_miss_o) |-> mem_valid);
  a_r8_fill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |-> mem_addr[OFF_W-1:0] == '0);
  a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> !mem_valid && req_ready);
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_o, rd_miss_o, wr_miss_o}));
endmodule

bind wb_tag_ctrl wb_tag_ctrl_chk #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
  .hit_o(hit_o), .rd_miss_o(rd_miss_o), .wr_miss_o(wr_miss_o), .wb_o(wb_o));

// File: tb/tb_wb_tag_ctrl.sv
`timescale 1ns/1ps
module tb_wb_tag_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, mem_ready = 1'b1;
  logic [31:0] req_addr = '0;
  logic req_ready, mem_valid, mem_write, hit_o, rd_miss_o, wr_miss_o, wb_o;
  logic [31:0] mem_addr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wb_tag_ctrl dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .hit_o(hit_o), .rd_miss_o(rd_miss_o),
    .wr_miss_o(wr_miss_o), .wb_o(wb_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {write, addr, expect hit, expect write-back, write-back address}; set 0 unless noted
  localparam logic [66:0] VEC [16] = '{
    {1'b0, 32'h000, 1'b0, 1'b0, 32'h0},   // way0, invalid first (R5)
    {1'b1, 32'h040, 1'b0, 1'b0, 32'h0},   // way1 dirty (R6)
    {1'b0, 32'h080, 1'b0, 1'b0, 32'h0},   // way2
    {1'b1, 32'h0C0, 1'b0, 1'b0, 32'h0},   // way3 dirty
    {1'b0, 32'h044, 1'b1, 1'b0, 32'h0},   // hit way1 (R3, R4)
    {1'b0, 32'h100, 1'b0, 1'b0, 32'h0},   // LRU way0 clean
    {1'b0, 32'h140, 1'b0, 1'b0, 32'h0},   // LRU way2 clean
    {1'b0, 32'h180, 1'b0, 1'b1, 32'h0C0}, // LRU way3 dirty (R7)
    {1'b0, 32'h1C0, 1'b0, 1'b1, 32'h040}, // LRU way1 dirty
    {1'b1, 32'h108, 1'b1, 1'b0, 32'h0},   // write hit way0 (R6)
    {1'b0, 32'h010, 1'b0, 1'b0, 32'h0},   // set1 independent (R1)
    {1'b0, 32'h200, 1'b0, 1'b0, 32'h0},
    {1'b0, 32'h240, 1'b0, 1'b0, 32'h0},
    {1'b0, 32'h280, 1'b0, 1'b0, 32'h0},
    {1'b0, 32'h2C0, 1'b0, 1'b1, 32'h100}, // dirtied by write hit
    {1'b0, 32'h2C4, 1'b1, 1'b0, 32'h0}    // hit at rank 0
  };

  task automatic do_req(logic wr, logic [31:0] a, logic exp_hit, logic exp_wb, logic [31:0] wba);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 hit pulse", {31'b0, hit_o}, {31'b0, exp_hit});
    check("R10 rd_miss pulse", {31'b0, rd_miss_o}, {31'b0, !exp_hit && !wr});
    check("R10 wr_miss pulse", {31'b0, wr_miss_o}, {31'b0, !exp_hit && wr});
    check("R7 wb pulse", {31'b0, wb_o}, {31'b0, exp_wb});
    if (exp_hit) begin
      check("R3 no traffic on hit", {31'b0, mem_valid}, 32'd0);
    end else begin
      if (exp_wb) begin
        check("R7 write-back first", {30'b0, mem_valid, mem_write}, 32'd3);
        check("R7 write-back address", mem_addr, wba);
        @(negedge clk);
      end
      check("R8 fill read", {30'b0, mem_valid, mem_write}, 32'd2);
      check("R8 fill address", mem_addr, a & ~32'hF);
      check("R9 busy not ready", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      check("R9 ready after fill", {31'b0, req_ready}, 32'd1);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset ready", {31'b0, req_ready}, 32'd1);
    check("R2 reset mem_valid", {31'b0, mem_valid}, 32'd0);
    check("R2 reset pulses", {28'b0, hit_o, rd_miss_o, wr_miss_o, wb_o}, 32'd0);
    rst_n = 1'b1;
    foreach (VEC[i]) do_req(VEC[i][66], VEC[i][65:34], VEC[i][33], VEC[i][32], VEC[i][31:0]);
    @(negedge clk);
    check("R10 pulse lasts one cycle", {28'b0, hit_o, rd_miss_o, wr_miss_o, wb_o}, 32'd0);

    // stalled fill in set2, with a request offered while busy
    mem_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h020;
    @(negedge clk);
    req_addr = 32'h030;
    check("R10 rd_miss under stall", {31'b0, rd_miss_o}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 stalled fill held", {30'b0, mem_valid, mem_write}, 32'd2);
      check("R9 stalled address", mem_addr, 32'h020);
      check("R9 not ready", {31'b0, req_ready}, 32'd0);
      check("R9 busy request ignored", {28'b0, hit_o, rd_miss_o, wr_miss_o, wb_o}, 32'd0);
    end
    req_valid = 1'b0; mem_ready = 1'b1;
    @(negedge clk);
    check("R9 ready after release", {31'b0, req_ready}, 32'd1);
    do_req(1'b0, 32'h030, 1'b0, 1'b0, 32'h0); // R9: busy-time request was not taken
    do_req(1'b1, 32'h02C, 1'b1, 1'b0, 32'h0); // R1: same block, other offset hits

    // reset restores invalid state: former hit now misses (R2)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_req(1'b0, 32'h02C, 1'b0, 1'b0, 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule